// File: doc/BRIEF.md
# Split-Accumulator Sine Tone Generator

This block is a direct digital synthesis tone source. It keeps a 32-bit phase accumulator as two halves: a 24-bit fractional half and an 8-bit index half. Each clock is one sample. The fractional half adds the low part of the active tuning word. Its carry is held in a one-bit register, so the index half receives it one sample later. The index half addresses a 256-entry sine ROM, and each sample is emitted as a 3-bit amplitude code for an external resistor ladder.

Samples are counted in groups of 32 so that a downstream serializer can take them in bursts. A flag marks the last sample of every group. A tuning word written with the load strobe goes to a shadow register and becomes active only at the next group boundary. The phase offset input is sampled during reset and becomes the starting phase. At reset the fractional half also receives a fixed half-step lead, so the late carry shows up only as a constant phase shift. Active words at or above half the accumulator range would put the tone above half the sample rate, and a warning output shows when such a word is active. With a 32-bit word at 128 MS/s, one tuning LSB is about 0.03 Hz.

Top module: `dds_split_tone`

## Requirements
- R1: Each sample code equals the upper 3 bits (bits 7:5) of the 8-bit value round(127.5 + 127.5·sin(2π·i/256)), where i is the current 8-bit table index.
- R2: While reset is high, the index half is loaded from phase_ofs[31:24] and the fractional half from phase_ofs[23:0] + 0x800000 (modulo 2^24). The delayed carry, the active word, the shadow word and the pending state are cleared, and the group count restarts.
- R3: Define the ideal accumulator as the reset value plus the sum of the active words of all earlier samples. The table index equals its upper 8 bits minus the carry out of bit 23 produced by the most recent low-half addition.
- R4: The index wraps modulo 256. Any carry out of the index half is dropped.
- R5: grp_end is high during exactly one sample in every 32: the last sample of each group. The first group starts with the first sample after reset.
- R6: A word presented with tw_load is held in a shadow register. It becomes the active word starting with the first sample of the next group. The active word never changes inside a group.
- R7: If tw_load is asserted several times within one group, the last word wins. A load made during the boundary sample itself is applied at the following boundary, while the word already pending is applied at the current one.
- R8: alias_warn is high exactly when bit 31 of the active word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_in | input | 32 | Tuning word to load |
| tw_load | input | 1 | Captures tw_in into the shadow register |
| phase_ofs | input | 32 | Starting phase, sampled during reset |
| code_out | output | 3 | Amplitude code of the current sample |
| grp_end | output | 1 | High on the last sample of a group |
| alias_warn | output | 1 | Active word at or above half range |

## Verification
The bench first holds the block in reset with a range of phase offsets, which tells apart index-half and fractional-half reset loading. It then steps integer-only tuning words through all 256 values, one group each, which covers every table entry and wrap-around with no fractional carry. Next come fractional words of various sizes, including a forward step just under half range and a negative step. These separate the one-sample-late carry from an immediate carry and show the dropped high carry. Finally, loads placed mid-group, repeated within a group and placed in the boundary sample separate correct shadow timing from early or lost updates.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int ACC_W    = 32;
    localparam int IDX_W    = 8;
    localparam int LO_W     = ACC_W - IDX_W;
    localparam int ENTRY_W  = 8;
    localparam int CODE_W   = 3;
    localparam int TBL_LEN  = 1 << IDX_W;
    localparam int GRP_LEN  = 32;

    // half-step lead preloaded into the fractional half at reset
    localparam logic [LO_W-1:0] LEAD_OFS = LO_W'(1) << (LO_W - 1);

    typedef struct packed {
        logic [IDX_W-1:0] hi;
        logic [LO_W-1:0]  lo;
    } phase_t;

    typedef logic [ENTRY_W-1:0] rom_t [TBL_LEN];

    function automatic rom_t build_rom();
        rom_t r;
        real  amp;
        real  v;
        int   q;
        amp = (2.0 ** ENTRY_W - 1.0) / 2.0;
        for (int i = 0; i < TBL_LEN; i++) begin
            v = amp + amp * $sin(2.0 * 3.141592653589793 * i / TBL_LEN);
            q = $rtoi(v + 0.5);
            if (q > (1 << ENTRY_W) - 1) q = (1 << ENTRY_W) - 1;
            if (q < 0) q = 0;
            r[i] = ENTRY_W'(q);
        end
        return r;
    endfunction

endpackage

// File: rtl/dds_group_timer.sv
module dds_group_timer #(
    parameter int GRP_LEN = dds_pkg::GRP_LEN
) (
    input  logic clk,
    input  logic rst,
    output logic last
);
    localparam int CNT_W = (GRP_LEN > 1) ? $clog2(GRP_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GRP_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == CNT_MAX) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CNT_MAX);
endmodule

// File: rtl/dds_tune_shadow.sv
module dds_tune_shadow
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t word_in,
    input  logic   word_load,
    input  logic   boundary,
    output phase_t word_act,
    output logic   over_half
);
    phase_t shadow_q;
    phase_t active_q;
    logic   pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (boundary && pend_q) active_q <= shadow_q;
            if (word_load) begin
                shadow_q <= word_in;
                pend_q   <= 1'b1;
            end else if (boundary) begin
                pend_q   <= 1'b0;
            end
        end
    end

    assign word_act  = active_q;
    assign over_half = active_q.hi[IDX_W-1];
endmodule

// File: rtl/dds_split_acc.sv
module dds_split_acc
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_t           start_ph,
    input  phase_t           step,
    output logic [IDX_W-1:0] index,
    output logic             carry_late
);
    logic [LO_W-1:0]  lo_q;
    logic [IDX_W-1:0] hi_q;
    logic             cy_q;
    logic [LO_W:0]    lo_sum;

    assign lo_sum = {1'b0, lo_q} + {1'b0, step.lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= start_ph.lo + LEAD_OFS;
            hi_q <= start_ph.hi;
            cy_q <= 1'b0;
        end else begin
            lo_q <= lo_sum[LO_W-1:0];
            // carry from the previous addition enters now; overflow is dropped
            hi_q <= hi_q + step.hi + IDX_W'(cy_q);
            cy_q <= lo_sum[LO_W];
        end
    end

    assign index      = hi_q;
    assign carry_late = cy_q;
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
(
    input  logic [IDX_W-1:0]  index,
    output logic [CODE_W-1:0] code
);
    localparam rom_t ROM = build_rom();

    generate
        if (CODE_W <= ENTRY_W) begin : g_trunc
            assign code = ROM[index][ENTRY_W-1 -: CODE_W];
        end else begin : g_wide
            assign code = {ROM[index], {(CODE_W-ENTRY_W){1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/dds_split_tone.sv
module dds_split_tone
    import dds_pkg::*;
#(
    parameter int GROUP = GRP_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  tw_in,
    input  logic              tw_load,
    input  logic [ACC_W-1:0]  phase_ofs,
    output logic [CODE_W-1:0] code_out,
    output logic              grp_end,
    output logic              alias_warn
);
    phase_t           act_word;
    logic [IDX_W-1:0] idx_q;
    logic             carry_q;

    dds_group_timer #(.GRP_LEN(GROUP)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .last (grp_end)
    );

    dds_tune_shadow u_tune (
        .clk       (clk),
        .rst       (rst),
        .word_in   (phase_t'(tw_in)),
        .word_load (tw_load),
        .boundary  (grp_end),
        .word_act  (act_word),
        .over_half (alias_warn)
    );

    dds_split_acc u_acc (
        .clk        (clk),
        .rst        (rst),
        .start_ph   (phase_t'(phase_ofs)),
        .step       (act_word),
        .index      (idx_q),
        .carry_late (carry_q)
    );

    dds_sine_rom u_rom (
        .index (idx_q),
        .code  (code_out)
    );
endmodule

// File: rtl/dds_split_tone_chk.sv
module dds_split_tone_chk
    import dds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             grp_end,
    input logic [ACC_W-1:0] act_word,
    input logic [IDX_W-1:0] idx,
    input logic             carry_q,
    input logic [ACC_W-1:0] phase_ofs
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    p_reset_load_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (carry_q == 1'b0 && act_word == '0 &&
                        idx == $past(phase_ofs[ACC_W-1 -: IDX_W])));

    p_late_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(carry_q) && $past(act_word[ACC_W-1 -: IDX_W]) == '0)
        |-> idx == $past(idx));

    p_single_end_r5: assert property (@(posedge clk) disable iff (rst)
        grp_end |=> !grp_end);

    p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(grp_end)) |-> $stable(act_word));
endmodule

bind dds_split_tone dds_split_tone_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .grp_end   (grp_end),
    .act_word  (act_word),
    .idx       (idx_q),
    .carry_q   (carry_q),
    .phase_ofs (phase_ofs)
);

// File: tb/sim_dds_split_tone.sv
`timescale 1ns/1ps
module sim_dds_split_tone;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tw_in = '0;
    logic        tw_load = 1'b0;
    logic [31:0] phase_ofs = '0;
    logic [2:0]  code_out;
    logic        grp_end;
    logic        alias_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [31:0] m_acc;
    logic        m_cy;
    logic [31:0] m_act, m_shd;
    logic        m_pend;
    int          m_k;

    always #4 clk = ~clk;

    dds_split_tone u0 (
        .clk(clk), .rst(rst), .tw_in(tw_in), .tw_load(tw_load),
        .phase_ofs(phase_ofs), .code_out(code_out), .grp_end(grp_end),
        .alias_warn(alias_warn)
    );

    function automatic logic [2:0] exp_code(input logic [7:0] i);
        real v;
        int  e;
        v = $floor(127.5 + 127.5 * $sin(2.0 * 3.141592653589793 * i / 256.0) + 0.5);
        e = int'(v);
        if (e > 255) e = 255;
        return 3'(e / 32);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // compare outputs of the current sample, drive inputs, advance model, pass edge
    task automatic step(input bit ld, input logic [31:0] w, input string tag);
        logic [7:0]  ei;
        logic [24:0] s;
        bit          bnd;
        ei = m_acc[31:24] - 8'(m_cy);
        check(tag, "code", int'(code_out), int'(exp_code(ei)));
        check("R5", "grp_end", int'(grp_end), int'(m_k == 31));
        check("R8", "alias_warn", int'(alias_warn), int'(m_act[31]));
        tw_load = ld;
        tw_in   = w;
        s     = {1'b0, m_acc[23:0]} + {1'b0, m_act[23:0]};
        m_cy  = s[24];
        m_acc = m_acc + m_act;
        bnd   = (m_k == 31);
        if (bnd && m_pend) m_act = m_shd;
        if (ld) begin
            m_shd  = w;
            m_pend = 1'b1;
        end else if (bnd) begin
            m_pend = 1'b0;
        end
        m_k = (m_k + 1) % 32;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] p);
        rst = 1'b1;
        tw_load = 1'b0;
        phase_ofs = p;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_acc  = {p[31:24], p[23:0] + 24'h800000};
        m_cy   = 1'b0;
        m_act  = '0;
        m_shd  = '0;
        m_pend = 1'b0;
        m_k    = 0;
    endtask

    initial begin
        @(negedge clk);
        // R2: reset state and idle first group
        do_reset(32'h4000_0000);
        step(0, '0, "R2");
        for (int i = 0; i < 40; i++) step(0, '0, "R6");

        // R1 / R4: every integer step size, one group each
        for (int t = 0; t < 256; t++) begin
            step(1, {8'(t), 24'h0}, "R1");
            for (int j = 0; j < 31; j++) step(0, '0, "R4");
        end

        // R3: fractional words exercising the late carry
        step(1, 32'h00C0_0000, "R3");
        for (int j = 0; j < 95; j++) step(0, '0, "R3");
        step(1, 32'h0155_5555, "R3");
        for (int j = 0; j < 95; j++) step(0, '0, "R3");
        step(1, 32'h7FFF_FFFF, "R3");
        for (int j = 0; j < 95; j++) step(0, '0, "R3");
        // R4 / R8: negative step wraps the index, above half range
        step(1, 32'hFF40_0000, "R4");
        for (int j = 0; j < 95; j++) step(0, '0, "R8");

        // R7: several loads in one group, then a load in the boundary sample
        while (m_k != 3) step(0, '0, "R7");
        step(1, 32'h0312_3456, "R7");
        step(0, '0, "R7");
        step(1, 32'h0987_6543, "R7");
        while (m_k != 31) step(0, '0, "R6");
        step(1, 32'h0540_0001, "R7");
        for (int j = 0; j < 70; j++) step(0, '0, "R7");

        // R2: a range of starting phases
        for (int p = 0; p < 16; p++) begin
            do_reset({8'(p * 16 + 3), 24'(p * 24'h0F1357)});
            step(0, '0, "R2");
            step(1, 32'h0280_0000, "R2");
            for (int j = 0; j < 36; j++) step(0, '0, "R3");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule